// File: doc/BRIEF.md
# Transmit Event Statistics Counter

This block tallies four kinds of transmit-side events reported by a transmit engine: frames that suffered exactly one collision, frames that suffered several collisions, frames whose start was deferred, and frames that were deferred for too long. Each kind has its own 4-bit counter. The four counters sit side by side in a single 16-bit word that a host reads as one register.

When any counter steps past its top value and wraps to zero, a sticky rollover flag is set. The flag is offered to the host as a status bit. It also raises an interrupt request, but only while an interrupt enable input is high. One read strobe hands the host the current word. On the clock edge that ends the strobe cycle, the block clears all four counters and the rollover flag, so the interrupt request keeps asserting until software reads the word. An event that arrives in the same cycle as the clearing read is not lost: it is counted into the cleared value.

Top module: `tx_event_stats`

## Requirements
- R1: After reset, rd_data is 0, roll_flag is 0 and irq is 0.
- R2: An event pulse sampled at a clock edge adds one to its own field, and rd_data shows the new value after that edge. The fields are: single collisions in bits 3:0, multiple collisions in bits 7:4, deferred transmits in bits 11:8 and excessively deferred transmits in bits 15:12. All fields can count in the same cycle.
- R3: A field that holds 15 and receives an event becomes 0.
- R4: A wrap of any field sets roll_flag at that clock edge.
- R5: During a cycle with rd_stb high, rd_data shows the values from before the read. After that edge, all four fields and roll_flag are 0.
- R6: An event in the same cycle as rd_stb leaves its field at 1 after the edge, and it does not set roll_flag.
- R7: irq is high exactly when roll_flag and irq_en are both high. It follows irq_en in the same cycle.
- R8: An event on one field leaves the other three fields unchanged.
- R9: Once roll_flag is set, it stays set until a read strobe, whatever further events arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_one_col | input | 1 | Frame sent after a single collision |
| ev_multi_col | input | 1 | Frame sent after multiple collisions |
| ev_deferred | input | 1 | Frame transmission was deferred |
| ev_long_defer | input | 1 | Frame transmission was excessively deferred |
| rd_stb | input | 1 | Host read of the counter word; clears it at the edge |
| irq_en | input | 1 | Rollover interrupt enable |
| rd_data | output | 16 | Packed counter word |
| roll_flag | output | 1 | Sticky rollover status |
| irq | output | 1 | Rollover interrupt request |

## Verification
Assertions check the following on every cycle:
- each field holds steady when it has no event and no read (R8);
- each field steps by exactly one on an event (R2, R3);
- a read returns each field to zero, or to one when an event arrives in the same cycle (R5, R6);
- the rollover flag only rises after a wrap and stays set until a read (R4, R9).

The bench's scenarios cover what those local rules cannot show:
- the bit position of each field in the host word;
- that rd_data shows the values from before the clear during the read cycle;
- the masking of irq by irq_en;
- long mixed sequences, checked against an arithmetic model across every event combination.

// File: rtl/tx_event_stats_pkg.sv
package tx_event_stats_pkg;
  localparam int unsigned CNT_W    = 4;
  localparam int unsigned N_EVENTS = 4;
  localparam int unsigned WORD_W   = CNT_W * N_EVENTS;
endpackage

// File: rtl/tes_field_cnt.sv
module tes_field_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] base;
  logic [W-1:0] cnt_next;
  logic         cnt_en;

  always_comb begin
    base     = clr ? '0 : cnt;
    cnt_next = base + W'(inc);
    cnt_en   = inc | clr;
  end

  assign wrap = inc & ~clr & (cnt == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_next;
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt == W'($past(cnt) + 1'b1)));
  // R5
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt == '0));
  // R6
  clear_keeps_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> (cnt == W'(1)));
endmodule

// File: rtl/tes_roll_flag.sv
module tes_roll_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_next;

  always_comb flag_next = clr ? 1'b0 : (flag | set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next;
  end

  // R4
  rise_needs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set));
  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R5
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
endmodule

// File: rtl/tx_event_stats.sv
module tx_event_stats
  import tx_event_stats_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_one_col,
  input  logic              ev_multi_col,
  input  logic              ev_deferred,
  input  logic              ev_long_defer,
  input  logic              rd_stb,
  input  logic              irq_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              roll_flag,
  output logic              irq
);
  logic [N_EVENTS-1:0] ev_vec;
  logic [N_EVENTS-1:0] wrap_vec;
  logic                any_wrap;

  assign ev_vec = {ev_long_defer, ev_deferred, ev_multi_col, ev_one_col};

  for (genvar i = 0; i < N_EVENTS; i++) begin : g_field
    tes_field_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_vec[i]),
      .clr   (rd_stb),
      .cnt   (rd_data[i*CNT_W +: CNT_W]),
      .wrap  (wrap_vec[i])
    );
  end

  assign any_wrap = |wrap_vec;

  tes_roll_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (any_wrap),
    .clr   (rd_stb),
    .flag  (roll_flag)
  );

  assign irq = roll_flag & irq_en;

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  // R4
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wrap && !rd_stb) |=> roll_flag);
endmodule

// File: tb/tx_event_stats_tb.sv
module tx_event_stats_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_one_col = 1'b0, ev_multi_col = 1'b0, ev_deferred = 1'b0, ev_long_defer = 1'b0;
  logic        rd_stb = 1'b0, irq_en = 1'b0;
  logic [15:0] rd_data;
  logic        roll_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  int exp_f [4];
  bit exp_flag = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tx_event_stats u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_one_col(ev_one_col), .ev_multi_col(ev_multi_col),
    .ev_deferred(ev_deferred), .ev_long_defer(ev_long_defer),
    .rd_stb(rd_stb), .irq_en(irq_en),
    .rd_data(rd_data), .roll_flag(roll_flag), .irq(irq)
  );

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    for (int i = 0; i < 4; i++) w[i*4 +: 4] = 4'(exp_f[i]);
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] ev, input bit rd, input bit en, input string req);
    bit wrap;
    int base;
    {ev_long_defer, ev_deferred, ev_multi_col, ev_one_col} = ev;
    rd_stb = rd;
    irq_en = en;
    #1;
    if (rd) check("R5", "word during read", rd_data, exp_word());
    check("R7", "irq", {15'd0, irq}, {15'd0, exp_flag & en});
    @(posedge clk);
    wrap = 1'b0;
    for (int i = 0; i < 4; i++) begin
      base = rd ? 0 : exp_f[i];
      if (ev[i] && !rd && exp_f[i] == 15) wrap = 1'b1;
      exp_f[i] = (base + int'(ev[i])) % 16;
    end
    exp_flag = rd ? 1'b0 : (exp_flag | wrap);
    @(negedge clk);
    check(req, "word", rd_data, exp_word());
    check(req, "flag", {15'd0, roll_flag}, {15'd0, exp_flag});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_f[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_en = 1'b1;
    #1;
    // R1 reset state
    check("R1", "word", rd_data, 16'h0000);
    check("R1", "flag", {15'd0, roll_flag}, 16'd0);
    check("R1", "irq", {15'd0, irq}, 16'd0);
    @(negedge clk);
    // R8 / R2: each field alone, checks its position
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < f + 2; k++) step(4'(1 << f), 1'b0, 1'b1, "R8");
    // R3 wrap of field 0 and R4 flag set
    for (int k = 0; k < 14; k++) step(4'b0001, 1'b0, 1'b1, "R3");
    check("R3", "field0 at zero", {12'd0, rd_data[3:0]}, 16'd0);
    check("R4", "flag after wrap", {15'd0, roll_flag}, 16'd1);
    // R9 sticky under further events
    for (int k = 0; k < 6; k++) step(4'b1111, 1'b0, 1'b1, "R9");
    // R7 masking
    for (int k = 0; k < 3; k++) step(4'b0000, 1'b0, 1'b0, "R7");
    step(4'b0000, 1'b0, 1'b1, "R7");
    // R5 clearing read
    step(4'b0000, 1'b1, 1'b1, "R5");
    check("R5", "word zero", rd_data, 16'h0000);
    // R6 event with read
    for (int k = 0; k < 9; k++) step(4'b1010, 1'b0, 1'b1, "R2");
    step(4'b1111, 1'b1, 1'b1, "R6");
    check("R6", "word ones", rd_data, 16'h1111);
    check("R6", "no flag", {15'd0, roll_flag}, 16'd0);
    // R2 sweep over all event combinations
    for (int c = 0; c < 600; c++)
      step(4'((c * 7) ^ (c >> 3)), (c % 37) == 36, c[5], "R2");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule